// File: doc/BRIEF.md
# Negotiated SMBASE Window Lock

This block guards a 128 KiB region of low memory that firmware reserves for system-management code. It holds one byte-wide configuration register and a three-state, one-way state machine behind it. Software first enables the feature by writing a negotiation code to the register. It then seals the feature by writing a lock code. From that point until reset, any access to the region that does not carry the system-management qualifier is cut off. A write is dropped. A read is answered with all ones. Accesses that carry the qualifier, and all addresses outside the region, still reach RAM.

The block sits between a memory requester and the RAM. Requests flow through valid/ready.
- An accepted request that the block forwards leaves on the RAM side in the same cycle.
- A blocked request is accepted in that cycle whatever the RAM's ready says.
- The block keeps at most one read in flight. It holds `req_ready` low until that read's response has been returned.
- Responses carry no back-pressure. The requester must take `rsp_valid` in the cycle it is shown.
- Writes produce no response.

A build parameter selects a compatibility variant. In that variant the register is a plain read/write byte and it never affects memory traffic.

Top module: `smb_window_guard`

## Requirements
- R1: After reset the register at configuration offset 0x9C reads 0x00, and non-qualified accesses to the region reach RAM.
- R2: In the idle state, any write at offset 0x9C whose value is not 0xFF is ignored, and the register keeps reading 0x00.
- R3: In the idle state, writing 0xFF at offset 0x9C enables the feature, and from the next cycle the register reads 0x01.
- R4: In the enabled state, writing 0x02 locks the feature, and from the next cycle the register reads 0x02. Any other value written in the enabled state is ignored, and the register keeps reading 0x01.
- R5: In the locked state every write of any value is ignored, and the register reads 0x02 until reset.
- R6: Before the lock, reads and writes to the region are forwarded to RAM, and reads return the RAM data.
- R7: While locked, a non-qualified write with address in 0x30000..0x4FFFF is accepted in the cycle it is presented, even if RAM is not ready, and it never raises `ram_valid`.
- R8: While locked, a non-qualified read in the region is accepted without any RAM access. It is answered with `rsp_data` = 0xFF in the cycle after acceptance.
- R9: While locked, qualified accesses reach RAM. Non-qualified accesses at 0x2FFFF and 0x50000, just outside the region, also reach RAM.
- R10: Reset returns the state machine to idle. The RAM contents written before the lock become visible again, and the region is writable again.
- R11: With `LEGACY_MODE` = 1, each of the 256 byte values written at offset 0x9C reads back unchanged, and the region is never blocked.
- R12: After a read is accepted, `req_ready` stays low until its response has been shown. A forwarded request is accepted only while `ram_ready` is high.
- R13: Writes at offsets other than 0x9C have no effect, and reads at other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request accepted |
| req_addr | input | 32 | Memory request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | System-management qualifier |
| req_wdata | input | 8 | Memory write data |
| ram_valid | output | 1 | Forwarded request valid |
| ram_ready | input | 1 | RAM can take a request |
| ram_addr | output | 32 | Forwarded address |
| ram_write | output | 1 | Forwarded write flag |
| ram_wdata | output | 8 | Forwarded write data |
| ram_rsp_valid | input | 1 | RAM read data valid |
| ram_rsp_data | input | 8 | RAM read data |
| rsp_valid | output | 1 | Read response valid to the requester |
| rsp_data | output | 8 | Read response data |

## Verification
The bench walks the negotiation sequence through near-miss values: the lock code written while still idle, 0xFE, and 0xFF repeated once the feature is enabled. A machine that used a plain write-enable, or that accepted codes in the wrong state, would read back the wrong byte. Probes at 0x2FFFF, 0x4FFFF and 0x50000 catch an off-by-one in the region decode. Each probe either leaks to RAM or blocks memory outside the region. Stalling RAM exposes a gate that makes blocked requests wait on `ram_ready`, or that lets a second request in while a read is still in flight. A reset followed by a read of the earlier RAM pattern shows whether the lock really clears. The legacy build is swept over all 256 values to catch any hidden filtering.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_OPEN = 2'd1,
    LK_SHUT = 2'd2
  } lock_state_e;

  typedef enum logic [1:0] {
    GT_IDLE = 2'd0,
    GT_RAM  = 2'd1,
    GT_FILL = 2'd2
  } gate_state_e;

  localparam logic [7:0] RB_IDLE = 8'h00;
  localparam logic [7:0] RB_OPEN = 8'h01;
  localparam logic [7:0] RB_SHUT = 8'h02;

endpackage

// File: rtl/smb_lock_fsm.sv
module smb_lock_fsm
  import smb_pkg::*;
#(
  parameter int              CFG_AW      = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h9C,
  parameter logic [7:0]      NEG_CODE    = 8'hFF,
  parameter logic [7:0]      LOCK_CODE   = 8'h02,
  parameter bit              LEGACY_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              lock_active
);

  logic       hit;
  logic [7:0] value;

  assign hit       = (cfg_addr == CFG_OFFSET);
  assign cfg_rdata = hit ? value : 8'h00;

  generate
    if (LEGACY_MODE) begin : g_plain
      logic [7:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             byte_q <= 8'h00;
        else if (cfg_we && hit) byte_q <= cfg_wdata;
      end

      assign value       = byte_q;
      assign lock_active = 1'b0;

    end else begin : g_negotiated
      lock_state_e st_q;
      lock_state_e st_d;

      always_comb begin
        st_d = st_q;
        if (cfg_we && hit) begin
          unique case (st_q)
            LK_IDLE: if (cfg_wdata == NEG_CODE)  st_d = LK_OPEN;
            LK_OPEN: if (cfg_wdata == LOCK_CODE) st_d = LK_SHUT;
            default: st_d = st_q;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_IDLE;
        else        st_q <= st_d;
      end

      always_comb begin
        unique case (st_q)
          LK_OPEN: value = RB_OPEN;
          LK_SHUT: value = RB_SHUT;
          default: value = RB_IDLE;
        endcase
      end

      assign lock_active = (st_q == LK_SHUT);

      // R5: once sealed, nothing but reset reopens the window
      a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> lock_active);

      // R2: in idle, a non-negotiation write leaves the readback at zero
      a_r2_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (value == RB_IDLE && cfg_we && hit && cfg_wdata != NEG_CODE)
          |=> (value == RB_IDLE));

      // R4: in the enabled state, only the lock code moves the machine
      a_r4_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (value == RB_OPEN && !(cfg_we && hit && cfg_wdata == LOCK_CODE))
          |=> (value == RB_OPEN));
    end
  endgenerate

endmodule

// File: rtl/smb_window_decode.sv
module smb_window_decode #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window
);

  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic above_base;
  logic below_end;

  assign above_base = (addr >= WIN_BASE);
  assign below_end  = ({1'b0, addr} < WIN_END);
  assign in_window  = above_base && below_end;

endmodule

// File: rtl/smb_access_gate.sv
module smb_access_gate
  import smb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_write,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic              ram_rsp_valid,
  input  logic [DATA_W-1:0] ram_rsp_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b1}};

  gate_state_e g_q;
  gate_state_e g_d;
  logic        free;
  logic        take;

  assign free      = (g_q == GT_IDLE);
  assign req_ready = free && (blocked || ram_ready);
  assign take      = req_valid && req_ready;

  assign ram_valid = req_valid && free && !blocked;
  assign ram_addr  = req_addr;
  assign ram_write = req_write;
  assign ram_wdata = req_wdata;

  always_comb begin
    g_d = g_q;
    unique case (g_q)
      GT_IDLE: if (take && !req_write) g_d = blocked ? GT_FILL : GT_RAM;
      GT_RAM:  if (ram_rsp_valid)      g_d = GT_IDLE;
      GT_FILL: g_d = GT_IDLE;
      default: g_d = GT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_q <= GT_IDLE;
    else        g_q <= g_d;
  end

  assign rsp_valid = (g_q == GT_FILL) || ((g_q == GT_RAM) && ram_rsp_valid);
  assign rsp_data  = (g_q == GT_FILL) ? FILL : ram_rsp_data;

  // R12: an accepted read closes the request port for the next cycle
  a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write) |=> !req_ready);

  // R8: a blocked read is answered with all ones one cycle later
  a_r8_fill_response: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && blocked) |=> (rsp_valid && rsp_data == FILL));

endmodule

// File: rtl/smb_window_guard.sv
module smb_window_guard
  import smb_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 8,
  parameter int                CFG_AW      = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET  = 8'h9C,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE    = 32'h0002_0000,
  parameter bit                LEGACY_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_write,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic              ram_rsp_valid,
  input  logic [DATA_W-1:0] ram_rsp_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic lock_active;
  logic in_win;
  logic blocked;

  smb_lock_fsm #(
    .CFG_AW      (CFG_AW),
    .CFG_OFFSET  (CFG_OFFSET),
    .NEG_CODE    (8'hFF),
    .LOCK_CODE   (8'h02),
    .LEGACY_MODE (LEGACY_MODE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .lock_active (lock_active)
  );

  smb_window_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_dec (
    .addr      (req_addr),
    .in_window (in_win)
  );

  assign blocked = lock_active && in_win && !req_smm;

  smb_access_gate #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .blocked       (blocked),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_write     (req_write),
    .req_wdata     (req_wdata),
    .ram_valid     (ram_valid),
    .ram_ready     (ram_ready),
    .ram_addr      (ram_addr),
    .ram_write     (ram_write),
    .ram_wdata     (ram_wdata),
    .ram_rsp_valid (ram_rsp_valid),
    .ram_rsp_data  (ram_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  // R7: a locked, unqualified access to the region never reaches RAM
  a_r7_no_ram_leak: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_active && in_win && !req_smm) |-> !ram_valid);

  // R9: qualified traffic is never held back by the lock
  a_r9_smm_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_smm && req_ready) |-> ram_valid);

endmodule

// File: tb/smb_window_guard_tb_top.sv
module smb_ram_model (
  input  logic        clk,
  input  logic        stall,
  input  logic        valid,
  output logic        ready,
  input  logic [31:0] addr,
  input  logic        write,
  input  logic [7:0]  wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output int          hits
);
  logic [7:0] mem [logic [31:0]];

  assign ready = !stall;

  initial begin
    rsp_valid = 1'b0;
    rsp_data  = 8'h00;
    hits      = 0;
  end

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (valid && ready) begin
      hits <= hits + 1;
      if (write) begin
        mem[addr] = wdata;
      end else begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem.exists(addr) ? mem[addr] : 8'h00;
      end
    end
  end
endmodule

module smb_window_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h9C;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        req_write = 1'b0;
  logic        req_smm = 1'b0;
  logic [7:0]  req_wdata = 8'h00;
  logic        stall = 1'b0;
  logic        sel_leg = 1'b0;

  logic [7:0]  d_cfg_rdata, l_cfg_rdata;
  logic        d_req_ready, l_req_ready;
  logic        d_ram_valid, l_ram_valid, d_ram_ready, l_ram_ready;
  logic [31:0] d_ram_addr, l_ram_addr;
  logic        d_ram_write, l_ram_write;
  logic [7:0]  d_ram_wdata, l_ram_wdata;
  logic        d_ram_rv, l_ram_rv;
  logic [7:0]  d_ram_rd, l_ram_rd;
  logic        d_rsp_valid, l_rsp_valid;
  logic [7:0]  d_rsp_data, l_rsp_data;
  int          d_hits, l_hits;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smb_window_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(d_cfg_rdata),
    .req_valid(req_valid), .req_ready(d_req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_smm(req_smm), .req_wdata(req_wdata),
    .ram_valid(d_ram_valid), .ram_ready(d_ram_ready), .ram_addr(d_ram_addr),
    .ram_write(d_ram_write), .ram_wdata(d_ram_wdata),
    .ram_rsp_valid(d_ram_rv), .ram_rsp_data(d_ram_rd),
    .rsp_valid(d_rsp_valid), .rsp_data(d_rsp_data)
  );

  smb_window_guard #(.LEGACY_MODE(1'b1)) dut_leg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(l_cfg_rdata),
    .req_valid(req_valid), .req_ready(l_req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_smm(req_smm), .req_wdata(req_wdata),
    .ram_valid(l_ram_valid), .ram_ready(l_ram_ready), .ram_addr(l_ram_addr),
    .ram_write(l_ram_write), .ram_wdata(l_ram_wdata),
    .ram_rsp_valid(l_ram_rv), .ram_rsp_data(l_ram_rd),
    .rsp_valid(l_rsp_valid), .rsp_data(l_rsp_data)
  );

  smb_ram_model u_ram_d (
    .clk(clk), .stall(stall), .valid(d_ram_valid), .ready(d_ram_ready),
    .addr(d_ram_addr), .write(d_ram_write), .wdata(d_ram_wdata),
    .rsp_valid(d_ram_rv), .rsp_data(d_ram_rd), .hits(d_hits)
  );

  smb_ram_model u_ram_l (
    .clk(clk), .stall(1'b0), .valid(l_ram_valid), .ready(l_ram_ready),
    .addr(l_ram_addr), .write(l_ram_write), .wdata(l_ram_wdata),
    .rsp_valid(l_ram_rv), .rsp_data(l_ram_rd), .hits(l_hits)
  );

  logic       m_req_ready, m_rsp_valid;
  logic [7:0] m_rsp_data, m_cfg_rdata;
  int         m_hits;

  always_comb begin
    m_req_ready = sel_leg ? l_req_ready : d_req_ready;
    m_rsp_valid = sel_leg ? l_rsp_valid : d_rsp_valid;
    m_rsp_data  = sel_leg ? l_rsp_data  : d_rsp_data;
    m_cfg_rdata = sel_leg ? l_cfg_rdata : d_cfg_rdata;
    m_hits      = sel_leg ? l_hits      : d_hits;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    cfg_addr  = off;
    cfg_wdata = val;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we   = 1'b0;
    cfg_addr = 8'h9C;
  endtask

  task automatic cfg_read(input logic [7:0] off, output logic [7:0] val);
    @(negedge clk);
    cfg_addr = off;
    #1 val = m_cfg_rdata;
    cfg_addr = 8'h9C;
  endtask

  // one access; returns read data and whether the port closed after a read
  task automatic mem_op(input logic [31:0] a, input bit wr, input bit smm,
                        input logic [7:0] wd, output logic [7:0] rd,
                        output bit closed);
    int guard;
    @(negedge clk);
    req_addr  = a;
    req_write = wr;
    req_smm   = smm;
    req_wdata = wd;
    req_valid = 1'b1;
    #1;
    guard = 0;
    while (!m_req_ready && guard < 20) begin
      @(negedge clk);
      #1 guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1 closed = !m_req_ready;
    rd = 8'h00;
    if (!wr) begin
      guard = 0;
      while (!m_rsp_valid && guard < 5) begin
        @(negedge clk);
        #1 guard++;
      end
      rd = m_rsp_valid ? m_rsp_data : 8'hXX;
    end
  endtask

  typedef struct packed {
    logic [7:0] wr;
    logic [7:0] exp;
  } vec_t;

  // negotiation walk: idle ignores (R2), enable (R3), open ignores and lock (R4), locked ignores (R5)
  localparam vec_t VEC [12] = '{
    '{8'h00, 8'h00}, '{8'h55, 8'h00}, '{8'h02, 8'h00}, '{8'hFE, 8'h00},
    '{8'hFF, 8'h01}, '{8'hFF, 8'h01}, '{8'h00, 8'h01}, '{8'h03, 8'h01},
    '{8'h02, 8'h02}, '{8'hFF, 8'h02}, '{8'h01, 8'h02}, '{8'h00, 8'h02}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rb;
    logic [7:0] rd;
    bit         cl;
    int         h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cfg_read(8'h9C, rb);
    check(rb == 8'h00, "R1 reset readback", rb, 8'h00);

    // R13: other offsets have no effect
    cfg_write(8'h9D, 8'hFF);
    cfg_read(8'h9D, rb);
    check(rb == 8'h00, "R13 other offset reads zero", rb, 8'h00);
    cfg_read(8'h9C, rb);
    check(rb == 8'h00, "R13 other offset write ignored", rb, 8'h00);

    // R6: region behaves as RAM before the lock
    h0 = d_hits;
    mem_op(32'h0003_0000, 1'b1, 1'b0, 8'h32, rd, cl);
    mem_op(32'h0003_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h32, "R6 region read before lock", rd, 8'h32);
    check(d_hits == h0 + 2, "R6 RAM hit count", d_hits, h0 + 2);
    check(cl, "R12 port closed while read in flight", 0, 1);

    for (int i = 0; i < 12; i++) begin
      cfg_write(8'h9C, VEC[i].wr);
      cfg_read(8'h9C, rb);
      check(rb == VEC[i].exp, $sformatf("R2/R3/R4/R5 vector %0d", i), rb, VEC[i].exp);
    end

    // R7: blocked write dropped, accepted even with RAM stalled
    stall = 1'b1;
    h0 = d_hits;
    @(negedge clk);
    req_addr = 32'h0003_0000; req_write = 1'b1; req_smm = 1'b0;
    req_wdata = 8'h77; req_valid = 1'b1;
    #1 check(d_req_ready == 1'b1, "R7 blocked write accepted under stall", d_req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    stall = 1'b0;
    check(d_hits == h0, "R7 blocked write no RAM access", d_hits, h0);

    // R8: blocked read returns all ones
    h0 = d_hits;
    mem_op(32'h0003_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'hFF, "R8 blocked read data", rd, 8'hFF);
    check(d_hits == h0, "R8 no RAM access", d_hits, h0);
    mem_op(32'h0004_FFFF, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'hFF, "R8 last byte of region blocked", rd, 8'hFF);

    // R9: qualified and out-of-region traffic passes
    mem_op(32'h0003_0000, 1'b0, 1'b1, 8'h00, rd, cl);
    check(rd == 8'h32, "R9 qualified read sees RAM", rd, 8'h32);
    mem_op(32'h0002_FFFF, 1'b1, 1'b0, 8'h41, rd, cl);
    mem_op(32'h0002_FFFF, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h41, "R9 below region", rd, 8'h41);
    mem_op(32'h0005_0000, 1'b1, 1'b0, 8'h42, rd, cl);
    mem_op(32'h0005_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h42, "R9 above region", rd, 8'h42);

    // R12: forwarded request waits on RAM ready
    stall = 1'b1;
    @(negedge clk);
    req_addr = 32'h0002_FFFF; req_write = 1'b0; req_smm = 1'b0; req_valid = 1'b1;
    #1 check(d_req_ready == 1'b0, "R12 forwarded waits for RAM", d_req_ready, 0);
    @(negedge clk);
    #1 check(d_req_ready == 1'b0, "R12 still waiting", d_req_ready, 0);
    stall = 1'b0;
    #1 check(d_req_ready == 1'b1, "R12 accepted once RAM ready", d_req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check(d_rsp_valid && d_rsp_data == 8'h41, "R12 stalled read data", d_rsp_data, 8'h41);

    // R10: reset clears the lock, earlier RAM visible
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_read(8'h9C, rb);
    check(rb == 8'h00, "R10 readback after reset", rb, 8'h00);
    mem_op(32'h0003_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h32, "R10 earlier RAM visible", rd, 8'h32);
    mem_op(32'h0003_0000, 1'b1, 1'b0, 8'h23, rd, cl);
    mem_op(32'h0003_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h23, "R10 region writable again", rd, 8'h23);

    // R11: compatibility build stores every value and never blocks
    sel_leg = 1'b1;
    for (int v = 0; v < 256; v++) begin
      cfg_write(8'h9C, v[7:0]);
      cfg_read(8'h9C, rb);
      check(rb == v[7:0], "R11 legacy readback", rb, v);
    end
    cfg_write(8'h9C, 8'hFF);
    cfg_write(8'h9C, 8'h02);
    mem_op(32'h0003_0000, 1'b1, 1'b0, 8'h5A, rd, cl);
    mem_op(32'h0003_0000, 1'b0, 1'b0, 8'h00, rd, cl);
    check(rd == 8'h5A, "R11 legacy region stays RAM", rd, 8'h5A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule